// File: doc/BRIEF.md
# Coherence-state controller for data-cache lines

The block keeps a three-state coherence record (Invalid, Exclusive, Modified) for every line of a small data cache. It turns each processor request into a local cache action and zero, one or two bus operations. A request is one of five kinds: load, load-reserve, store, store-conditional or block flush. It comes with a line index, a write-through attribute, a cache-inhibit attribute, a reservation flag and a flag that says the victim way holds modified data. The block decides from the recorded state and the attributes whether the request is served from the cache, strobes a read or write of the data array, and places bus requests on a valid/ready queue port. Each bus request carries a kind, a beat count and the line index.

A request is held at the input until its last bus operation is taken. When a request needs a castout or a block push as well as its main operation, the push goes out first. A separate fill port records the state a line reaches when a refill from the bus completes. The data array, tag lookup, snooping and bus timing sit outside the block.

Top module: `mei_line_ctrl`

## Requirements
- R1: After reset every line reads Invalid. `line_state` always shows the recorded state of the line at `req_idx`, with the state codes Invalid=0, Exclusive=1, Modified=2. Request op codes are load=0, store=1, load-reserve=2, store-conditional=3, flush=4.
- R2: A load with `req_ci` low on an Invalid line emits a 4-beat read. When `victim_mod` is high, a 4-beat write-with-kill castout comes before the read. The line state is unchanged.
- R3: A load with `req_ci` low on an Exclusive or Modified line pulses `rd_hit` on acceptance. It emits no bus operation and leaves the state unchanged.
- R4: A load with `req_ci` high emits one 1-beat read in every state and leaves the state unchanged.
- R5: A store with both `req_wt` and `req_ci` low on an Invalid line emits a 4-beat RWITM. When `victim_mod` is high, a 4-beat write-with-kill castout comes first. The state is unchanged.
- R6: A store with both attributes low on an Exclusive or Modified line pulses `wr_hit`, emits no bus operation and sets the line to Modified.
- R7: A store with `req_wt` high and `req_ci` low never changes the state. On Invalid it emits a 1-beat write-with-flush. On Exclusive it pulses `wr_hit` and emits a 1-beat write-with-flush. On Modified it emits only a 4-beat write-with-kill push.
- R8: A store with `req_ci` high emits a 1-beat write-with-flush and never changes the state. When the line is Modified, a 4-beat write-with-kill push comes before the write-with-flush.
- R9: A flush on a Modified line emits a 4-beat write-with-kill. On an Invalid or Exclusive line it emits a 1-beat flush. In both cases the line ends Invalid.
- R10: The bus kind codes are read=0, RWITM=2, write-with-flush=4, write-with-kill=6 and flush=7. Load-reserve and successful store-conditional requests set bit 0 of the read, RWITM and write-with-flush codes. Pushes and castouts never set it.
- R11: A store-conditional with `req_rsv` high behaves as a store. With `req_rsv` low it emits nothing and leaves the state unchanged. On acceptance `sc_done` pulses, with `sc_ok` equal to `req_rsv`.
- R12: `req_ready` is high when there is no request or the request needs no bus operation. Otherwise it is high only in the cycle its last bus operation is taken. `bus_valid` stays high and `req_ready` stays low while `bus_ready` is low.
- R13: A fill sets its line to Modified when `fill_mod` is high and to Exclusive otherwise. If a request is accepted on the same line in the same cycle, the request's update wins.
- R14: Op codes 5 to 7 are accepted at once. They emit no bus operation, no strobe, and leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, held until accepted |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_op | input | 3 | Request op code |
| req_idx | input | IW | Line index |
| req_wt | input | 1 | Write-through attribute |
| req_ci | input | 1 | Cache-inhibit attribute |
| req_rsv | input | 1 | Reservation held |
| victim_mod | input | 1 | Victim way holds modified data |
| fill_valid | input | 1 | Refill completed |
| fill_idx | input | IW | Refilled line |
| fill_mod | input | 1 | Refill gives ownership with modify |
| line_state | output | 2 | Recorded state of line req_idx |
| next_state | output | 2 | State the line takes if the request is accepted |
| rd_hit | output | 1 | Read data from cache |
| wr_hit | output | 1 | Write data into cache |
| sc_done | output | 1 | Store-conditional accepted |
| sc_ok | output | 1 | Store-conditional succeeded |
| bus_valid | output | 1 | Bus request present |
| bus_ready | input | 1 | Queue takes the bus request |
| bus_kind | output | 3 | Bus operation kind |
| bus_beats | output | 3 | Beat count, 1 or 4 |
| bus_idx | output | IW | Line index of the bus request |

## Verification
On every cycle the assertions check these properties: a stalled queue holds the request; a cache read hit never drives the bus; a failed store-conditional stays silent; and a flush or copy-back store hit leaves its line in the expected state on the next cycle. The choice of bus kind, beat count and ordering for each combination of attributes, state and victim flag shows only in the bench scenarios. The same holds for the reserved variants and for a fill that collides with a request. The bench compares every output each cycle against its own reference model.

// File: rtl/mei_line_ctrl.sv
module mei_line_ctrl #(
  parameter int LINES = 64,
  localparam int IW = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [IW-1:0] req_idx,
  input  logic          req_wt,
  input  logic          req_ci,
  input  logic          req_rsv,
  input  logic          victim_mod,
  input  logic          fill_valid,
  input  logic [IW-1:0] fill_idx,
  input  logic          fill_mod,
  output logic [1:0]    line_state,
  output logic [1:0]    next_state,
  output logic          rd_hit,
  output logic          wr_hit,
  output logic          sc_done,
  output logic          sc_ok,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic [2:0]    bus_kind,
  output logic [2:0]    bus_beats,
  output logic [IW-1:0] bus_idx
);
  localparam logic [1:0] S_I = 2'd0, S_E = 2'd1, S_M = 2'd2;
  localparam logic [2:0] OP_LD = 3'd0, OP_ST = 3'd1, OP_LR = 3'd2, OP_SC = 3'd3, OP_FL = 3'd4;
  localparam logic [2:0] K_RD = 3'd0, K_RWITM = 3'd2, K_WWF = 3'd4, K_WWK = 3'd6, K_FL = 3'd7;
  localparam logic [2:0] ONE = 3'd1, FOUR = 3'd4;

  logic [1:0] tbl [LINES];
  logic       ph;
  logic [1:0] cur, ns, nops;
  logic [2:0] k0, k1, b0, b1, rv;
  logic       rd, wr, acc, go_st;

  assign rv    = {2'b00, (req_op == OP_LR) || (req_op == OP_SC)};
  assign go_st = (req_op == OP_ST) || (req_op == OP_SC && req_rsv);

  always_comb begin
    cur  = tbl[req_idx];
    ns   = cur;
    nops = 2'd0;
    k0 = K_RD; k1 = K_RD; b0 = ONE; b1 = ONE;
    rd = 1'b0; wr = 1'b0;
    case (req_op)
      OP_LD, OP_LR: begin
        if (req_ci) begin
          nops = 2'd1; k0 = K_RD | rv;
        end else if (cur == S_I) begin
          if (victim_mod) begin
            nops = 2'd2; k0 = K_WWK; b0 = FOUR; k1 = K_RD | rv; b1 = FOUR;
          end else begin
            nops = 2'd1; k0 = K_RD | rv; b0 = FOUR;
          end
        end else rd = 1'b1;
      end
      OP_ST, OP_SC: begin
        if (go_st) begin
          if (req_ci) begin
            if (cur == S_M) begin
              nops = 2'd2; k0 = K_WWK; b0 = FOUR; k1 = K_WWF | rv;
            end else begin
              nops = 2'd1; k0 = K_WWF | rv;
            end
          end else if (req_wt) begin
            nops = 2'd1;
            if (cur == S_M) begin
              k0 = K_WWK; b0 = FOUR;
            end else begin
              k0 = K_WWF | rv; wr = (cur == S_E);
            end
          end else if (cur == S_I) begin
            if (victim_mod) begin
              nops = 2'd2; k0 = K_WWK; b0 = FOUR; k1 = K_RWITM | rv; b1 = FOUR;
            end else begin
              nops = 2'd1; k0 = K_RWITM | rv; b0 = FOUR;
            end
          end else begin
            wr = 1'b1; ns = S_M;
          end
        end
      end
      OP_FL: begin
        nops = 2'd1; ns = S_I;
        if (cur == S_M) begin
          k0 = K_WWK; b0 = FOUR;
        end else k0 = K_FL;
      end
      default: ;
    endcase
  end

  assign bus_valid  = req_valid && (nops != 2'd0);
  assign bus_kind   = ph ? k1 : k0;
  assign bus_beats  = ph ? b1 : b0;
  assign bus_idx    = req_idx;
  assign req_ready  = !req_valid || (nops == 2'd0) || (bus_ready && (ph || nops == 2'd1));
  assign acc        = req_valid && req_ready;
  assign rd_hit     = acc && rd;
  assign wr_hit     = acc && wr;
  assign sc_done    = acc && (req_op == OP_SC);
  assign sc_ok      = sc_done && req_rsv;
  assign line_state = cur;
  assign next_state = ns;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= 1'b0;
      for (int i = 0; i < LINES; i++) tbl[i] <= S_I;
    end else begin
      if (acc) ph <= 1'b0;
      else if (bus_valid && bus_ready && nops == 2'd2) ph <= 1'b1;
      if (fill_valid) tbl[fill_idx] <= fill_mod ? S_M : S_E;
      if (acc) tbl[req_idx] <= ns;
    end
  end

  p_stall_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |-> !req_ready);

  p_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> !bus_valid);

  p_sc_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op == OP_SC && !req_rsv |-> req_ready && !bus_valid && sc_done && !sc_ok);

  p_flush_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc && req_op == OP_FL |=> tbl[$past(req_idx)] == S_I);

  p_store_mod_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && !req_wt && !req_ci |=> tbl[$past(req_idx)] == S_M);
endmodule

// File: tb/sim_mei_line_ctrl.sv
`timescale 1ns/1ps
module sim_mei_line_ctrl;
  localparam int LINES = 4;
  localparam int IW = 2;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_wt = 0, req_ci = 0, req_rsv = 0, victim_mod = 0;
  logic [2:0] req_op = 0;
  logic [IW-1:0] req_idx = 0, fill_idx = 0, bus_idx;
  logic fill_valid = 0, fill_mod = 0, bus_ready = 0;
  logic req_ready, rd_hit, wr_hit, sc_done, sc_ok, bus_valid;
  logic [1:0] line_state, next_state;
  logic [2:0] bus_kind, bus_beats;
  int total = 0, bad = 0, cyc = 0;
  int mst [LINES];
  int mph = 0;
  bit acc_prev = 0, finished = 0;

  always #5 clk = ~clk;

  mei_line_ctrl #(.LINES(LINES)) u0 (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d cyc=%0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic model(output int n, output int k0, output int b0, output int k1,
                       output int b1, output int ns, output bit rd, output bit wr,
                       output string tag);
    int s = mst[req_idx];
    int r = (req_op == 2 || req_op == 3) ? 1 : 0;
    n = 0; k0 = 0; b0 = 1; k1 = 0; b1 = 1; ns = s; rd = 0; wr = 0; tag = "R14";
    if (req_op == 0 || req_op == 2) begin
      tag = (req_op == 2) ? "R10" : "R2";
      if (req_ci) begin n = 1; k0 = r; if (req_op == 0) tag = "R4"; end
      else if (s == 0) begin
        if (victim_mod) begin n = 2; k0 = 6; b0 = 4; k1 = r; b1 = 4; end
        else begin n = 1; k0 = r; b0 = 4; end
      end else begin rd = 1; if (req_op == 0) tag = "R3"; end
    end else if (req_op == 1 || req_op == 3) begin
      tag = (req_op == 3) ? "R11" : "R5";
      if (req_op == 1 || req_rsv) begin
        if (req_ci) begin
          if (req_op == 1) tag = "R8";
          if (s == 2) begin n = 2; k0 = 6; b0 = 4; k1 = 4 + r; end
          else begin n = 1; k0 = 4 + r; end
        end else if (req_wt) begin
          if (req_op == 1) tag = "R7";
          n = 1;
          if (s == 2) begin k0 = 6; b0 = 4; end
          else begin k0 = 4 + r; wr = (s == 1); end
        end else if (s == 0) begin
          if (victim_mod) begin n = 2; k0 = 6; b0 = 4; k1 = 2 + r; b1 = 4; end
          else begin n = 1; k0 = 2 + r; b0 = 4; end
        end else begin
          wr = 1; ns = 2; if (req_op == 1) tag = "R6";
        end
      end
    end else if (req_op == 4) begin
      tag = "R9"; n = 1; ns = 0;
      if (s == 2) begin k0 = 6; b0 = 4; end else k0 = 7;
    end
    if (fill_valid && fill_idx == req_idx) tag = "R13";
  endtask

  always @(negedge clk) begin
    int n, k0, b0, k1, b1, ns;
    bit rd, wr, rdy, acc;
    string tag;
    cyc++;
    chk("R1", "line_state", line_state, rst_n ? mst[req_idx] : 0);
    if (rst_n && !finished) begin
      model(n, k0, b0, k1, b1, ns, rd, wr, tag);
      rdy = !req_valid || n == 0 || (bus_ready && (mph == 1 || n == 1));
      acc = req_valid && rdy;
      chk("R12", "req_ready", req_ready, rdy);
      chk(tag, "bus_valid", bus_valid, req_valid && n != 0);
      if (req_valid && n != 0) begin
        chk(tag, "bus_kind", bus_kind, mph ? k1 : k0);
        chk(tag, "bus_beats", bus_beats, mph ? b1 : b0);
        chk(tag, "bus_idx", bus_idx, req_idx);
      end
      if (req_valid) chk(tag, "next_state", next_state, ns);
      chk(tag, "rd_hit", rd_hit, acc && rd);
      chk(tag, "wr_hit", wr_hit, acc && wr);
      chk("R11", "sc_done", sc_done, acc && req_op == 3);
      chk("R11", "sc_ok", sc_ok, acc && req_op == 3 && req_rsv);
      if (acc) mph = 0;
      else if (req_valid && n == 2 && bus_ready) mph = 1;
      if (fill_valid) mst[fill_idx] = fill_mod ? 2 : 1;
      if (acc) mst[req_idx] = ns;
      acc_prev = acc;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) mst[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk); #1;
      if (acc_prev || !req_valid) begin
        int p = $urandom_range(0, 99);
        req_valid  = $urandom_range(0, 99) < 85;
        req_op     = p < 22 ? 3'd0 : p < 44 ? 3'd1 : p < 56 ? 3'd2 : p < 72 ? 3'd3 : p < 94 ? 3'd4 : 3'($urandom_range(5, 7));
        req_idx    = IW'($urandom_range(0, LINES - 1));
        req_wt     = $urandom_range(0, 3) == 0;
        req_ci     = $urandom_range(0, 3) == 0;
        req_rsv    = $urandom_range(0, 1) == 1;
        victim_mod = $urandom_range(0, 1) == 1;
      end
      fill_valid = $urandom_range(0, 99) < 25;
      fill_idx   = IW'($urandom_range(0, LINES - 1));
      fill_mod   = $urandom_range(0, 1) == 1;
      bus_ready  = $urandom_range(0, 99) < 65;
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++;
    $display("FAIL R12 watchdog act=%0d exp=%0d", cyc, 5000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule